// File: doc/BRIEF.md
# Way-Reserving Shared Cache for Multithreaded Cores

This block is a set-associative cache shared by several hardware threads. A thread can be given a number of ways in every set that only it may fill. The ways left over are open to all threads. Because of this, one thread can never evict every line of another, which limits eviction-based timing leakage between threads. Each request carries a thread number and an address. A lookup hits on any valid line whose tag matches, whatever thread filled it. On a miss the line is installed from the fill data that comes with the request. The victim is chosen only among the ways that thread is allowed to use.

Software sets the reservation count with a configuration write. A legal new value does not take effect at once. The block first walks all sets, one per cycle, and clears every way whose owner changes between the old and the new setting. Requests are refused while the walk runs. An out-of-range value is dropped and sets a sticky error flag. With a reservation of zero the block is an ordinary LRU set-associative cache. At the largest legal value the ways are split evenly between the threads and no shared ways remain.

Top module: `nmc_cache`

## Requirements
- R1: After reset there is no response, busy is low, the reservation reads 0, the error flag is low, and every line is invalid.
- R2: An accepted request gives exactly one response in the cycle after acceptance. On a hit, rspHit is 1, rspWay is the matching way and rspData is the stored data, even when another thread filled the line.
- R3: On a miss, rspHit is 0, rspData equals the request's fill data, rspWay names the victim way, and that way then holds the new tag and data.
- R4: With reservation 0 all 8 ways are eligible. The lowest-numbered invalid way is chosen first. When none is invalid, the least recently used way is chosen, where both hits and fills count as uses.
- R5: With reservation Y > 0, thread t owns ways t*Y to t*Y+Y-1 and ways 2*Y to 7 are shared. A missing thread picks only among its own and the shared ways, taking the lowest invalid one first and otherwise the least recently used one.
- R6: At reservation 4, thread 0 fills only ways 0-3 and thread 1 fills only ways 4-7, even when the other half holds invalid or older lines.
- R7: A legal write whose value differs from the current one raises busy from the next cycle for exactly 8 cycles (one per set). The old value stays visible during that time. The new value appears as busy falls. In every set, each way whose owner changes is made invalid, and all other lines are kept.
- R8: A request made while busy is high is not accepted. It produces no response and changes no line.
- R9: A write of a value above 4 is ignored and sets an error flag that stays set until reset. A write during busy is ignored. A write of the current value starts no walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqThread | input | 1 | Requesting thread number |
| reqAddr | input | 8 | Address: bits 2:0 set index, bits 7:3 tag |
| reqData | input | 16 | Fill data installed on a miss |
| rspValid | output | 1 | Response strobe |
| rspHit | output | 1 | Response was a hit |
| rspWay | output | 3 | Way that hit or was filled |
| rspData | output | 16 | Line data |
| cfgWrite | input | 1 | Reservation write strobe |
| cfgResv | input | 4 | Requested reservation count per thread |
| resvY | output | 4 | Reservation count in force |
| busy | output | 1 | Invalidation walk in progress |
| cfgErr | output | 1 | Sticky flag for an out-of-range write |

## Verification
The bench fills a full set and then reuses it so the LRU order is known exactly. A design that replaced the wrong line, or that left hits out of the age update, would report the wrong victim way. At full reservation, thread 1 is given older and invalid lines in the other half of the set; a design that leaked across owners would evict one of them. Across the change from 4 to 1, one line whose owner stays the same must still hit and lines whose owner changes must miss. A design that cleared too much, too little, or applied the new value before the walk ended would show up there or in the busy length. Refused requests, out-of-range writes, rewrites of the same value and writes during the walk must each leave lines and settings untouched. A design that accepted any of them would give an unexpected response or a wrong hit result.

// File: rtl/nmc_pkg.sv
package nmc_pkg;
  parameter int NC_WAYS    = 8;
  parameter int NC_THREADS = 2;
  parameter int NC_SETS    = 8;

  localparam int WAY_W    = $clog2(NC_WAYS);
  localparam int THR_W    = (NC_THREADS > 1) ? $clog2(NC_THREADS) : 1;
  localparam int SET_W    = $clog2(NC_SETS);
  localparam int RESV_MAX = NC_WAYS / NC_THREADS;
  localparam int RESV_W   = $clog2(NC_WAYS + 1);
  localparam int OWN_W    = $clog2(NC_THREADS + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic               accept;
    logic               walkEn;
    logic [SET_W-1:0]   walkSet;
    logic [NC_WAYS-1:0] clrMask;
  } ctrlStrobe_t;

  // owner code of a way: thread number, or NC_THREADS when shared
  function automatic logic [OWN_W-1:0] wayOwner(input logic [WAY_W-1:0] way,
                                                 input logic [RESV_W-1:0] resv);
    logic [OWN_W-1:0] own;
    int lo;
    own = OWN_W'(NC_THREADS);
    for (int t = 0; t < NC_THREADS; t++) begin
      lo = t * int'(resv);
      if (int'(way) >= lo && int'(way) < lo + int'(resv))
        own = OWN_W'(t);
    end
    return own;
  endfunction
endpackage

// File: rtl/nmc_ctrl.sv
module nmc_ctrl
  import nmc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              cfgWrite,
  input  logic [RESV_W-1:0] cfgResv,
  output ctrlStrobe_t       strobe,
  output logic              busy,
  output logic [RESV_W-1:0] resvY,
  output logic              cfgErr
);
  logic [RESV_W-1:0]  pendY;
  logic [SET_W-1:0]   walkIdx;
  logic [NC_WAYS-1:0] clrMask;
  logic [NC_WAYS-1:0] changeMask;
  logic               cfgLegal;
  logic               walkLast;

  // ways whose owner differs between the current and the requested setting
  for (genvar w = 0; w < NC_WAYS; w++) begin : gChange
    assign changeMask[w] = wayOwner(WAY_W'(w), resvY) != wayOwner(WAY_W'(w), cfgResv);
  end

  assign cfgLegal = cfgResv <= RESV_W'(RESV_MAX);
  assign walkLast = walkIdx == SET_W'(NC_SETS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      resvY   <= '0;
      pendY   <= '0;
      walkIdx <= '0;
      clrMask <= '0;
      cfgErr  <= 1'b0;
    end else if (busy) begin
      if (walkLast) begin
        busy  <= 1'b0;
        resvY <= pendY;
      end
      walkIdx <= walkIdx + SET_W'(1);
    end else if (cfgWrite) begin
      if (!cfgLegal) begin
        cfgErr <= 1'b1;
      end else if (cfgResv != resvY) begin
        busy    <= 1'b1;
        pendY   <= cfgResv;
        walkIdx <= '0;
        clrMask <= changeMask;
      end
    end
  end

  always_comb begin
    strobe.accept  = reqValid && !busy;
    strobe.walkEn  = busy;
    strobe.walkSet = walkIdx;
    strobe.clrMask = clrMask;
  end
endmodule

// File: rtl/nmc_datapath.sv
module nmc_datapath
  import nmc_pkg::*;
#(
  parameter  int TAG_W  = 5,
  parameter  int DATA_W = 16,
  localparam int ADDR_W = TAG_W + SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [RESV_W-1:0] resvY,
  input  logic [THR_W-1:0]  reqThread,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WAY_W-1:0]  rspWay,
  output logic [DATA_W-1:0] rspData
);
  logic [NC_WAYS-1:0] validArr [NC_SETS];
  logic [TAG_W-1:0]   tagArr   [NC_SETS][NC_WAYS];
  logic [DATA_W-1:0]  dataArr  [NC_SETS][NC_WAYS];
  logic [WAY_W-1:0]   ageArr   [NC_SETS][NC_WAYS];

  logic [SET_W-1:0]   reqSet;
  logic [TAG_W-1:0]   reqTag;
  logic [NC_WAYS-1:0] hitVec;
  logic [NC_WAYS-1:0] eligVec;
  logic               isHit;
  logic [WAY_W-1:0]   hitWay;
  logic [WAY_W-1:0]   invWay;
  logic               invFound;
  logic [WAY_W-1:0]   lruWay;
  logic [WAY_W-1:0]   bestAge;
  logic               lruFound;
  logic [WAY_W-1:0]   useWay;
  logic [WAY_W-1:0]   refAge;

  assign reqSet = reqAddr[SET_W-1:0];
  assign reqTag = reqAddr[ADDR_W-1:SET_W];

  for (genvar w = 0; w < NC_WAYS; w++) begin : gWay
    assign hitVec[w]  = validArr[reqSet][w] && (tagArr[reqSet][w] == reqTag);
    assign eligVec[w] = (wayOwner(WAY_W'(w), resvY) == OWN_W'(reqThread)) ||
                        (wayOwner(WAY_W'(w), resvY) == OWN_W'(NC_THREADS));
  end

  assign isHit = |hitVec;

  always_comb begin
    hitWay   = '0;
    invWay   = '0;
    invFound = 1'b0;
    lruWay   = '0;
    bestAge  = '0;
    lruFound = 1'b0;
    for (int w = NC_WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
      if (eligVec[w] && !validArr[reqSet][w]) begin
        invWay   = WAY_W'(w);
        invFound = 1'b1;
      end
    end
    for (int w = 0; w < NC_WAYS; w++) begin
      if (eligVec[w] && (!lruFound || ageArr[reqSet][w] > bestAge)) begin
        lruWay   = WAY_W'(w);
        bestAge  = ageArr[reqSet][w];
        lruFound = 1'b1;
      end
    end
    if (isHit)         useWay = hitWay;
    else if (invFound) useWay = invWay;
    else               useWay = lruWay;
    refAge = ageArr[reqSet][useWay];
  end

  // valid bits and ages
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NC_SETS; s++) begin
        validArr[s] <= '0;
        for (int w = 0; w < NC_WAYS; w++) ageArr[s][w] <= WAY_W'(w);
      end
    end else if (strobe.walkEn) begin
      validArr[strobe.walkSet] <= validArr[strobe.walkSet] & ~strobe.clrMask;
    end else if (strobe.accept) begin
      if (!isHit) validArr[reqSet][useWay] <= 1'b1;
      for (int w = 0; w < NC_WAYS; w++) begin
        if (WAY_W'(w) == useWay)          ageArr[reqSet][w] <= '0;
        else if (ageArr[reqSet][w] < refAge) ageArr[reqSet][w] <= ageArr[reqSet][w] + WAY_W'(1);
      end
    end
  end

  // tag and data store with fill port
  always_ff @(posedge clk) begin
    if (strobe.accept && !isHit) begin
      tagArr[reqSet][useWay]  <= reqTag;
      dataArr[reqSet][useWay] <= reqData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspWay   <= '0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.accept;
      if (strobe.accept) begin
        rspHit  <= isHit;
        rspWay  <= useWay;
        rspData <= isHit ? dataArr[reqSet][hitWay] : reqData;
      end
    end
  end
endmodule

// File: rtl/nmc_cache.sv
module nmc_cache
  import nmc_pkg::*;
#(
  parameter  int TAG_W  = 5,
  parameter  int DATA_W = 16,
  localparam int ADDR_W = TAG_W + SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [THR_W-1:0]  reqThread,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WAY_W-1:0]  rspWay,
  output logic [DATA_W-1:0] rspData,
  input  logic              cfgWrite,
  input  logic [RESV_W-1:0] cfgResv,
  output logic [RESV_W-1:0] resvY,
  output logic              busy,
  output logic              cfgErr
);
  ctrlStrobe_t strobe;

  nmc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cfgWrite (cfgWrite),
    .cfgResv  (cfgResv),
    .strobe   (strobe),
    .busy     (busy),
    .resvY    (resvY),
    .cfgErr   (cfgErr)
  );

  nmc_datapath #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .resvY     (resvY),
    .reqThread (reqThread),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspWay    (rspWay),
    .rspData   (rspData)
  );
endmodule

// File: rtl/nmc_cache_chk.sv
module nmc_cache_chk
  import nmc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [THR_W-1:0]  reqThread,
  input logic [DATA_W-1:0] reqData,
  input logic              rspValid,
  input logic              rspHit,
  input logic [WAY_W-1:0]  rspWay,
  input logic [DATA_W-1:0] rspData,
  input logic [RESV_W-1:0] resvY,
  input logic              busy,
  input logic              cfgErr
);
  // R2: a response only follows an accepted request
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && !busy));

  // R3: a miss returns the fill data
  assert_miss_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspData == $past(reqData)));

  // R5: a filled way is owned by the requester or shared
  assert_victim_eligible_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |->
      ((wayOwner(rspWay, $past(resvY)) == OWN_W'($past(reqThread))) ||
       (wayOwner(rspWay, $past(resvY)) == OWN_W'(NC_THREADS))));

  // R7: the reservation only changes as the walk ends
  assert_resv_at_walk_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resvY) |-> $fell(busy));

  // R8: nothing is accepted during the walk
  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !rspValid);

  // R9: reservation stays in range, error is sticky
  assert_resv_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    resvY <= RESV_W'(RESV_MAX));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
endmodule

bind nmc_cache nmc_cache_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThread(reqThread),
  .reqData(reqData), .rspValid(rspValid), .rspHit(rspHit), .rspWay(rspWay),
  .rspData(rspData), .resvY(resvY), .busy(busy), .cfgErr(cfgErr)
);

// File: tb/tb_nmc_cache.sv
module tb_nmc_cache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [0:0]  reqThread = '0;
  logic [7:0]  reqAddr = '0;
  logic [15:0] reqData = '0;
  logic        rspValid, rspHit;
  logic [2:0]  rspWay;
  logic [15:0] rspData;
  logic        cfgWrite = 1'b0;
  logic [3:0]  cfgResv = '0;
  logic [3:0]  resvY;
  logic        busy, cfgErr;

  always #10 clk = ~clk;  // 50 MHz

  nmc_cache dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThread(reqThread),
    .reqAddr(reqAddr), .reqData(reqData), .rspValid(rspValid), .rspHit(rspHit),
    .rspWay(rspWay), .rspData(rspData), .cfgWrite(cfgWrite), .cfgResv(cfgResv),
    .resvY(resvY), .busy(busy), .cfgErr(cfgErr)
  );

  typedef struct {
    logic        hit;
    logic [2:0]  way;
    logic [15:0] data;
    string       rq;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [15:0] dat(input int tag, input int set);
    return 16'h5000 | 16'(tag << 4) | 16'(set);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // driver: one request, expected response pushed to the scoreboard
  task automatic req(input int thr, input int tag, input int set, input bit expHit,
                     input int expWay, input int expTagData, input string rq);
    expItem_t e;
    @(negedge clk);
    reqValid  = 1'b1;
    reqThread = 1'(thr);
    reqAddr   = 8'((tag << 3) | set);
    reqData   = dat(tag, set);
    e.hit = expHit; e.way = 3'(expWay); e.data = dat(expTagData, set); e.rq = rq;
    expQ.push_back(e);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // mode 1: request during walk; mode 2: second write during walk
  task automatic cfgSet(input int y, input int expBusy, input int expY,
                        input int mode, input string rq);
    int oldY;
    int n;
    oldY = int'(resvY);
    @(negedge clk);
    cfgWrite = 1'b1; cfgResv = 4'(y);
    @(negedge clk);
    cfgWrite = 1'b0;
    n = 0;
    while (busy && n < 50) begin
      chk(int'(resvY) == oldY, rq, "old reservation during walk", int'(resvY), oldY);
      if (n == 0 && mode == 1) begin
        reqValid = 1'b1; reqThread = 1'b0; reqAddr = 8'((20 << 3) | 3); reqData = 16'hdead;
      end else if (n == 0 && mode == 2) begin
        cfgWrite = 1'b1; cfgResv = 4'd3;
      end else begin
        reqValid = 1'b0; cfgWrite = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    reqValid = 1'b0; cfgWrite = 1'b0;
    chk(n == expBusy, rq, "busy cycles", n, expBusy);
    chk(int'(resvY) == expY, rq, "reservation after write", int'(resvY), expY);
  endtask

  // monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected response actual=1 expected=0");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (rspHit !== e.hit || rspWay !== e.way || rspData !== e.data) begin
          errors++;
          $display("FAIL %s hit/way/data actual=%0d/%0d/%h expected=%0d/%0d/%h",
                   e.rq, rspHit, rspWay, rspData, e.hit, e.way, e.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rspValid == 1'b0, "R1", "rspValid", int'(rspValid), 0);
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
    chk(resvY == 4'd0, "R1", "resvY", int'(resvY), 0);
    chk(cfgErr == 1'b0, "R1", "cfgErr", int'(cfgErr), 0);

    // R4 / R3: fill set 0 in way order, then LRU replacement
    for (int t = 1; t <= 8; t++) req(0, t, 0, 0, t - 1, t, "R3");
    req(1, 3, 0, 1, 2, 3, "R2");          // other thread hits
    req(1, 9, 0, 0, 0, 9, "R4");          // oldest is way 0
    req(0, 10, 0, 0, 1, 10, "R4");        // then way 1 (way 2 refreshed by hit)
    req(0, 9, 0, 1, 0, 9, "R2");

    // R7 / R8: move to 4, poke a request during the walk
    cfgSet(4, 8, 4, 1, "R7");
    req(0, 9, 0, 0, 0, 9, "R7");          // every way changed owner
    req(0, 20, 3, 0, 0, 20, "R8");        // refused request left no line

    // R6: thread 1 restricted to ways 4-7
    req(1, 1, 1, 0, 4, 1, "R6");
    req(1, 2, 1, 0, 5, 2, "R6");
    req(1, 3, 1, 0, 6, 3, "R6");
    req(1, 4, 1, 0, 7, 4, "R6");
    req(1, 5, 1, 0, 4, 5, "R6");          // ways 0-3 invalid and older, still not used
    req(0, 2, 1, 1, 5, 2, "R2");          // thread 0 hits thread 1's line

    // R7: 4 -> 1 keeps way 0, clears the rest
    req(0, 1, 2, 0, 0, 1, "R5");
    req(0, 2, 2, 0, 1, 2, "R5");
    cfgSet(1, 8, 1, 0, "R7");
    req(1, 1, 2, 1, 0, 1, "R7");          // kept
    req(1, 2, 2, 0, 1, 2, "R7");          // cleared, thread 1 now owns way 1
    req(0, 2, 1, 0, 0, 2, "R5");          // thread 0: own way 0 first

    // R9: out-of-range write
    @(negedge clk);
    cfgWrite = 1'b1; cfgResv = 4'd5;
    @(negedge clk);
    cfgWrite = 1'b0;
    chk(busy == 1'b0, "R9", "busy after bad write", int'(busy), 0);
    chk(resvY == 4'd1, "R9", "resvY after bad write", int'(resvY), 1);
    chk(cfgErr == 1'b1, "R9", "cfgErr after bad write", int'(cfgErr), 1);
    req(1, 1, 2, 1, 0, 1, "R9");          // lines untouched
    cfgSet(1, 0, 1, 0, "R9");             // same value: no walk

    // R5 shared ways, then R9 write during walk
    req(1, 1, 4, 0, 1, 1, "R5");
    req(1, 2, 4, 0, 2, 2, "R5");
    cfgSet(0, 8, 0, 2, "R9");             // second write (3) ignored
    chk(cfgErr == 1'b1, "R9", "cfgErr sticky", int'(cfgErr), 1);
    req(1, 2, 4, 1, 2, 2, "R7");          // shared way 2 kept
    req(1, 1, 4, 0, 0, 1, "R7");          // way 1 cleared, way 0 lowest invalid

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R2", "responses outstanding", expQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule